// File: doc/BRIEF.md
# Three-Channel Interval Timer

A bank of three 16-bit interval timer channels, compatible in programming model with the classic PC timer. Every channel counts the cycles of a shared tick enable, takes a gate input and drives one output pin. The waveform on that pin is chosen from six counting modes: interrupt on terminal count, retriggerable one-shot, rate generator, square wave, and software- or hardware-triggered strobe. A byte-wide port with four addresses reaches the block. Addresses 0 to 2 hold the channels' count registers. Address 3 takes control words.

A control word selects a channel, how its count bytes are moved and its counting mode. The count is then written through the channel's data address. The channel's timing restarts on the clock edge that accepts the last byte of the count. Reads return the current count. A latch command can freeze that count until software has read it. The output of channel 0 is registered onto an interrupt request line.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every channel is in mode 3 with a count of 65536 and two-byte access. All outputs are high and irq_o is low. Counting starts on the first tick after reset is released.
- R2: The control word at address 3 is decoded as follows. Bits 7:6 select the channel, and the value 3 is ignored. Bits 5:4 select the access: 00 is a latch command, 01 is low byte only, 10 is high byte only and 11 is low byte then high byte. Bits 3:1 select the mode, with 6 and 7 acting as 2 and 3. Bit 0 is accepted, but counting stays binary. Reads of address 3 return 0.
- R3: A count value of zero is treated as 65536.
- R4: In two-byte access, the low byte alone does not disturb the running timing. The new count and a fresh start take effect when the high byte is written.
- R5: A control word drives the output to the initial level of its mode, which is low for mode 0 and high for all other modes. The channel then halts until a count is written.
- R6: Modes 0 and 1 go low at the restart and go high once the elapsed ticks reach the count. The output then stays high.
- R7: Mode 2 repeats every count ticks. The output goes low for one tick at each period boundary, except at the restart itself.
- R8: Mode 3 repeats every count ticks. The output is high for (count+1)/2 ticks and low for the remaining ticks.
- R9: Modes 4 and 5 give a single one-tick low strobe when the elapsed ticks equal the count. There is no second strobe without a reload or a retrigger.
- R10: A rising edge on the gate restarts the timing in modes 1, 2, 3 and 5. In modes 0 and 4 a gate edge has no effect.
- R11: While tick_i is low the channel state holds.
- R12: A read returns the count minus the ticks elapsed in the current period, one byte per read. In two-byte access the low byte comes first. A latch command freezes this value until every byte of it has been read.
- R13: irq_o equals out_o[0] delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one tick per asserted cycle |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; advances the read byte pointer |
| addr_i | input | 2 | 0 to 2 channel data, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| gate_i | input | 3 | Gate per channel |
| out_o | output | 3 | Output pin per channel |
| irq_o | output | 1 | Registered copy of channel 0 output |

## Verification
Four properties are checked on every cycle:
- irq_o tracks out_o[0] one clock later.
- A control word for channel 0 forces that channel's output to its mode's initial level.
- The outputs hold still when there is no tick, no write and no gate change.
- Control reads return zero, and the outputs are high during reset.

The waveform shapes depend on count values, and so do the single-strobe rule, gate retriggering, two-byte loading and the effect of a zero count. These show only in the bench's scenarios. The bench compares each output and each read byte against its own model of elapsed ticks.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int EXT_W  = CNT_W + 1;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  // codes 6/7 alias 2/3
  function automatic mode_e fold_mode(input logic [2:0] raw);
    if (raw[2:1] == 2'b11) return mode_e'({1'b0, raw[1:0]});
    return mode_e'(raw);
  endfunction

  function automatic logic [EXT_W-1:0] norm_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? (EXT_W'(1) << CNT_W) : {1'b0, v};
  endfunction
endpackage

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic             halt_i,
  input  logic [EXT_W-1:0] count_i,
  input  mode_e            mode_i,
  output logic             out_o,
  output logic [CNT_W-1:0] cur_o
);
  logic             run_q, armed_q, gate_q;
  logic [EXT_W-1:0] elap_q, phase_q, half, rem;
  logic             retrig, gate_rise, phase_wrap;

  assign retrig     = mode_i inside {M_ONESHOT, M_RATE, M_SQUARE, M_HW_STROBE};
  assign gate_rise  = gate_i & ~gate_q;
  assign phase_wrap = (phase_q + 1'b1) == count_i;
  assign half       = (count_i + EXT_W'(1)) >> 1;
  assign rem        = count_i - phase_q;
  assign cur_o      = rem[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b1;
      armed_q <= 1'b1;
      gate_q  <= 1'b1;
      elap_q  <= '0;
      phase_q <= '0;
    end else begin
      gate_q <= gate_i;
      if (halt_i) begin
        run_q   <= 1'b0;
        armed_q <= 1'b0;
        elap_q  <= '0;
        phase_q <= '0;
      end else if (load_i || (gate_rise && armed_q && retrig)) begin
        run_q   <= 1'b1;
        armed_q <= 1'b1;
        elap_q  <= '0;
        phase_q <= '0;
      end else if (run_q && tick_i) begin
        // elapsed saturates one past the count
        if (elap_q <= count_i) elap_q <= elap_q + 1'b1;
        phase_q <= phase_wrap ? '0 : phase_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (mode_i)
      M_TC_INT:  out_o = run_q & (elap_q >= count_i);
      M_ONESHOT: out_o = ~run_q | (elap_q >= count_i);
      M_RATE:    out_o = ~(run_q & (phase_q == '0) & (elap_q != '0));
      M_SQUARE:  out_o = ~run_q | (phase_q < half);
      default:   out_o = ~(run_q & (elap_q == count_i));
    endcase
  end
endmodule

// File: rtl/pit_chan_port.sv
module pit_chan_port
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  acc_e              cfg_acc_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              snap_i,
  input  logic              dat_we_i,
  input  logic              dat_re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cur_i,
  output logic              load_o,
  output logic              halt_o,
  output logic [EXT_W-1:0]  count_o,
  output mode_e             mode_o,
  output logic [BYTE_W-1:0] rdata_o
);
  acc_e              acc_q;
  mode_e             mode_q;
  logic [EXT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] lo_q;
  logic              wr_hi_q, rd_hi_q, snap_vld_q;
  logic [CNT_W-1:0]  snap_q, rd_src;
  logic              rd_last, hi_sel;

  assign load_o  = dat_we_i & ((acc_q != ACC_WORD) | wr_hi_q);
  assign halt_o  = cfg_we_i;
  assign count_o = cnt_q;
  assign mode_o  = mode_q;
  assign rd_src  = snap_vld_q ? snap_q : cur_i;
  assign rd_last = (acc_q != ACC_WORD) | rd_hi_q;
  assign hi_sel  = (acc_q == ACC_HI) | ((acc_q == ACC_WORD) & rd_hi_q);
  assign rdata_o = hi_sel ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_WORD;
      mode_q     <= M_SQUARE;
      cnt_q      <= EXT_W'(1) << CNT_W;
      lo_q       <= '0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      snap_vld_q <= 1'b0;
      snap_q     <= '0;
    end else if (cfg_we_i) begin
      acc_q      <= cfg_acc_i;
      mode_q     <= fold_mode(cfg_mode_i);
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      snap_vld_q <= 1'b0;
    end else begin
      if (snap_i && !snap_vld_q) begin
        snap_q     <= cur_i;
        snap_vld_q <= 1'b1;
      end
      if (dat_we_i) begin
        case (acc_q)
          ACC_LO: cnt_q <= norm_count({{BYTE_W{1'b0}}, wdata_i});
          ACC_HI: cnt_q <= norm_count({wdata_i, {BYTE_W{1'b0}}});
          default: begin
            if (!wr_hi_q) begin
              lo_q    <= wdata_i;
              wr_hi_q <= 1'b1;
            end else begin
              cnt_q   <= norm_count({wdata_i, lo_q});
              wr_hi_q <= 1'b0;
            end
          end
        endcase
      end
      if (dat_re_i) begin
        if (acc_q == ACC_WORD) rd_hi_q <= ~rd_hi_q;
        if (rd_last) snap_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import pit_pkg::*;
#(
  parameter int NCH = 3  // at most 3: select field is 2 bits, code 3 reserved
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NCH-1:0]    gate_i,
  output logic [NCH-1:0]    out_o,
  output logic              irq_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic              cw_hit;
  logic [1:0]        cw_sel;
  acc_e              cw_acc;
  logic [BYTE_W-1:0] ch_rd [NCH];

  assign cw_hit = wr_i & (addr_i == CTRL_ADDR);
  assign cw_sel = wdata_i[7:6];
  assign cw_acc = acc_e'(wdata_i[5:4]);

  for (genvar i = 0; i < NCH; i++) begin : gen_ch
    logic             sel, load, halt;
    logic [EXT_W-1:0] count;
    mode_e            mode;
    logic [CNT_W-1:0] cur;

    assign sel = cw_hit & (cw_sel == 2'(i));

    pit_chan_port u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (sel & (cw_acc != ACC_LATCH)),
      .cfg_acc_i  (cw_acc),
      .cfg_mode_i (wdata_i[3:1]),
      .snap_i     (sel & (cw_acc == ACC_LATCH)),
      .dat_we_i   (wr_i & (addr_i == 2'(i))),
      .dat_re_i   (rd_i & (addr_i == 2'(i))),
      .wdata_i    (wdata_i),
      .cur_i      (cur),
      .load_o     (load),
      .halt_o     (halt),
      .count_o    (count),
      .mode_o     (mode),
      .rdata_o    (ch_rd[i])
    );

    pit_count_core u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .gate_i  (gate_i[i]),
      .load_i  (load),
      .halt_i  (halt),
      .count_i (count),
      .mode_i  (mode),
      .out_o   (out_o[i]),
      .cur_o   (cur)
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == 2'(i)) rdata_o = ch_rd[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= out_o[0];
  end
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick_i,
  input logic           wr_i,
  input logic           rd_i,
  input logic [1:0]     addr_i,
  input logic [7:0]     wdata_i,
  input logic [7:0]     rdata_o,
  input logic [NCH-1:0] gate_i,
  input logic [NCH-1:0] out_o,
  input logic           irq_o
);
  logic rst_q;

  always_ff @(posedge clk_i) rst_q <= ~rst_ni;

  always @(negedge clk_i) begin
    if (rst_q && !rst_ni) p_reset_out_r1: assert (out_o == '1);
  end

  p_irq_track_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(out_o[0]));

  p_cfg_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'd0 && wdata_i[5:4] != 2'd0)
      |=> out_o[0] == ($past(wdata_i[3:1]) != 3'd0));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i && $stable(gate_i)) |=> $stable(out_o));

  p_ctrl_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |-> rdata_o == 8'h00);
endmodule

bind tri_interval_timer tri_interval_timer_chk #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .gate_i  (gate_i),
  .out_o   (out_o),
  .irq_o   (irq_o)
);

// File: tb/tri_interval_timer_tb.sv
`timescale 1ns/1ps
module tri_interval_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] gate_i = 3'b011;
  logic [2:0] out_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  tri_interval_timer u_dut (
    .clk_i, .rst_ni, .tick_i, .wr_i, .rd_i, .addr_i,
    .wdata_i, .rdata_o, .gate_i, .out_o, .irq_o
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    summary();
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  // control word (two-byte access) then count; returns with 0 ticks elapsed
  task automatic load(input int ch, input int m, input int c);
    bus_wr(2'd3, {2'(ch), 2'b11, 3'(m), 1'b0});
    bus_wr(2'(ch), c[7:0]);
    bus_wr(2'(ch), c[15:8]);
  endtask

  function automatic logic exp_out(input int m, input int c, input int k);
    int r;
    r = k % c;
    case (m)
      0, 1:    return k >= c;
      2:       return !(r == 0 && k != 0);
      3:       return r < (c + 1) / 2;
      default: return k != c;
    endcase
  endfunction

  function automatic string mtag(input int m);
    case (m)
      0, 1:    return "R6";
      2:       return "R7";
      3:       return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    logic [7:0] b;
    int unsigned seed;
    seed = $urandom(32'h1c0ffee);

    adv(3);
    rst_ni = 1'b1;
    chk("R1 outputs high after reset", int'(out_o), 7);
    chk("R1 irq low after reset", int'(irq_o), 0);
    adv(10);
    bus_wr(2'd3, 8'h40);               // latch channel 1 at 10 ticks
    bus_rd(2'd1, b); chk("R1 R12 latched lsb", int'(b), 8'hF6);
    bus_rd(2'd1, b); chk("R1 R12 latched msb", int'(b), 8'hFF);
    bus_rd(2'd1, b); chk("R12 live lsb after latch released", int'(b), 8'hF3);

    // randomized mode/count sweep
    for (int it = 0; it < 24; it++) begin
      int ch, m, c;
      ch = int'($urandom % 3);
      m  = int'($urandom % 6);
      c  = 1 + int'($urandom % 40);
      load(ch, m, c);
      for (int k = 0; k <= 2 * c + 2; k++) begin
        chk(mtag(m), int'(out_o[ch]), int'(exp_out(m, c, k)));
        if (ch == 0 && k > 0) chk("R13 irq follows out0", int'(irq_o), int'(exp_out(m, c, k - 1)));
        adv(1);
      end
    end

    // R2: mode 7 aliases square wave
    load(0, 7, 6);
    for (int k = 0; k < 13; k++) begin
      chk("R2 mode 7 as mode 3", int'(out_o[0]), int'(exp_out(3, 6, k)));
      adv(1);
    end
    // R2: select code 3 ignored, control reads zero
    load(0, 0, 4);
    adv(4);
    bus_wr(2'd3, 8'hF0);
    chk("R2 select 3 ignored", int'(out_o[0]), 1);
    bus_rd(2'd3, b); chk("R2 control read zero", int'(b), 0);
    // R2: bcd flag accepted, binary counting
    bus_wr(2'd3, 8'h31); bus_wr(2'd0, 8'h10); bus_wr(2'd0, 8'h00);
    adv(15); chk("R2 bcd flag binary count k15", int'(out_o[0]), 0);
    adv(1);  chk("R2 bcd flag binary count k16", int'(out_o[0]), 1);
    // R2: high-byte-only access
    bus_wr(2'd3, 8'h20); bus_wr(2'd0, 8'h01);
    adv(255); chk("R2 msb-only count 256 k255", int'(out_o[0]), 0);
    adv(1);   chk("R2 msb-only count 256 k256", int'(out_o[0]), 1);

    // R3: zero count
    load(0, 2, 65536);
    adv(1);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, b); chk("R3 zero count lsb", int'(b), 8'hFF);
    bus_rd(2'd0, b); chk("R3 zero count msb", int'(b), 8'hFF);
    bus_wr(2'd3, 8'h10); bus_wr(2'd0, 8'h00);
    adv(300); chk("R3 lsb-only zero not terminal", int'(out_o[0]), 0);

    // R4: low byte alone keeps old timing
    load(0, 2, 10);
    adv(3);
    bus_wr(2'd0, 8'd20);                // k = 4
    adv(6); chk("R4 old period kept", int'(out_o[0]), 0);
    bus_wr(2'd0, 8'd0);                 // restart with 20
    adv(19); chk("R4 new count k19", int'(out_o[0]), 1);
    adv(1);  chk("R4 new count k20", int'(out_o[0]), 0);

    // R5: control word halts at initial level
    bus_wr(2'd3, 8'h30);
    chk("R5 mode 0 initial low", int'(out_o[0]), 0);
    adv(30); chk("R5 halted stays low", int'(out_o[0]), 0);
    bus_wr(2'd3, 8'h38);
    adv(20); chk("R5 mode 4 initial high", int'(out_o[0]), 1);

    // R6 R10: mode 1 retrigger on channel 2
    gate_i[2] = 1'b0;
    load(2, 1, 5);
    chk("R6 mode 1 low after load", int'(out_o[2]), 0);
    adv(5); chk("R6 mode 1 high at count", int'(out_o[2]), 1);
    gate_i[2] = 1'b1;
    adv(1); chk("R10 mode 1 gate retrigger", int'(out_o[2]), 0);
    adv(4); chk("R10 mode 1 k4", int'(out_o[2]), 0);
    adv(1); chk("R10 mode 1 k5", int'(out_o[2]), 1);

    // R10: mode 0 gate no effect
    gate_i[2] = 1'b0;
    load(2, 0, 5);
    adv(1); gate_i[2] = 1'b1;
    adv(3); chk("R10 mode 0 gate ignored k4", int'(out_o[2]), 0);
    adv(1); chk("R10 mode 0 gate ignored k5", int'(out_o[2]), 1);

    // R9 R10: mode 5 single strobe then retrigger
    gate_i[2] = 1'b0;
    load(2, 5, 4);
    adv(4);  chk("R9 mode 5 strobe", int'(out_o[2]), 0);
    adv(1);  chk("R9 strobe one tick", int'(out_o[2]), 1);
    adv(10); chk("R9 no second strobe", int'(out_o[2]), 1);
    gate_i[2] = 1'b1;
    adv(5);  chk("R10 mode 5 retrigger strobe", int'(out_o[2]), 0);

    // R10: mode 4 gate no effect
    gate_i[2] = 1'b0;
    load(2, 4, 3);
    adv(4); gate_i[2] = 1'b1;
    adv(3); chk("R10 mode 4 gate ignored", int'(out_o[2]), 1);

    // R11: tick hold
    load(0, 0, 5);
    adv(2);
    tick_i = 1'b0;
    adv(20); chk("R11 hold without tick", int'(out_o[0]), 0);
    tick_i = 1'b1;
    adv(2); chk("R11 resume k4", int'(out_o[0]), 0);
    adv(1); chk("R11 resume k5", int'(out_o[0]), 1);
    adv(1); chk("R13 irq after rise", int'(irq_o), 1);

    summary();
  end
endmodule